// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction RISC Core

This block is a 32-bit processor that finishes each instruction in one clock cycle. It supports register arithmetic and logic (add, subtract, bitwise and, bitwise or, signed set-less-than), word load and store with a base register plus a signed 16-bit displacement, branch-if-equal, and an absolute jump within the current 256 MB region. It holds a program counter, a 32-entry register file, one main ALU, an adder that computes branch targets on its own, the write-back and second-operand multiplexers, and the main control decoder.

Instruction memory and data memory are small internal word arrays. A load port writes words into either array. Software or a test environment normally does this while reset is held, then releases reset so execution starts at address 0. Debug outputs show the current PC and every register-file commit.

Top module: `mcore_top`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and rf_we_o is 0. After reset every general register reads as 0.
- R2: Opcode 0 with shamt 0 and funct 0x20, 0x22, 0x24 or 0x25 writes rs+rt, rs-rt (modulo 2^32), rs&rt or rs|rt into rd (bits 15:11). The register fields are rs at bits 25:21 and rt at bits 20:16.
- R3: Opcode 0 with funct 0x2A writes 1 into rd when rs is less than rt as signed two's-complement numbers, and writes 0 otherwise.
- R4: Opcode 0x23 reads the data word at rs + sign-extended bits 15:0 and writes it into rt. Address bits 1:0 are ignored.
- R5: Opcode 0x2B writes rt into the data word at rs + sign-extended bits 15:0 and writes no register.
- R6: Opcode 0x04 writes no register. When rs equals rt, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2. Otherwise the next PC is PC+4.
- R7: Opcode 0x02 writes no register. The next PC is bits 31:28 of PC+4 joined with bits 25:0 shifted left by 2.
- R8: Register 0 always reads as 0. A write to it is dropped and not reported on rf_we_o.
- R9: Any other opcode, an opcode-0 word with another funct, or an opcode-0 word with a nonzero shamt (bits 10:6) changes no register and no memory word, and the PC advances by 4.
- R10: When load_en_i is high at a rising clock edge, load_data_i is written to instruction-memory word load_addr_i if load_sel_i is 0, and to data-memory word load_addr_i if it is 1.
- R11: In the cycle an instruction commits a register write, rf_we_o is 1 and rf_waddr_o/rf_wdata_o carry the destination and the value. pc_o is the address of the instruction executing in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_en_i | input | 1 | Memory preload strobe |
| load_sel_i | input | 1 | Preload target: 0 instruction, 1 data memory |
| load_addr_i | input | max(IMEM_AW,DMEM_AW) | Preload word address |
| load_data_i | input | 32 | Preload word |
| pc_o | output | 32 | Address of the executing instruction |
| rf_we_o | output | 1 | Register commit this cycle |
| rf_waddr_o | output | 5 | Register being written |
| rf_wdata_o | output | 32 | Value being written |

## Verification
The hardest cases to reach from the ports are the ones that leave no trace on rf_we_o: a store, a dropped write to register 0, and unsupported encodings. The program therefore follows each of them with an instruction that exposes the state it might have changed. A load reads back the stored word. An add reads register 0 and the target of each dropped write. Branch and jump behaviour is checked through pc_o, cycle by cycle. A taken branch, a skipped branch and a self-loop branch with a negative offset are all included. A second program is loaded under reset to cover signed-compare extremes and the clearing of registers.

// File: rtl/mcore_pkg.sv
package mcore_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NREGS  = 32;
  localparam int unsigned RAW    = $clog2(NREGS);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/mcore_ctrl.sv
module mcore_ctrl
  import mcore_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  input  logic [4:0] shamt_i,
  output ctrl_t      ctrl_o
);
  logic    r_ok;
  alu_op_e r_op;

  always_comb begin
    r_ok = 1'b1;
    r_op = ALU_ADD;
    case (funct_i)
      FN_ADD:  r_op = ALU_ADD;
      FN_SUB:  r_op = ALU_SUB;
      FN_AND:  r_op = ALU_AND;
      FN_OR:   r_op = ALU_OR;
      FN_SLT:  r_op = ALU_SLT;
      default: r_ok = 1'b0;
    endcase
    if (shamt_i != 5'd0) r_ok = 1'b0;
  end

  always_comb begin
    ctrl_o.reg_dst    = 1'b0;
    ctrl_o.alu_src    = 1'b0;
    ctrl_o.mem_to_reg = 1'b0;
    ctrl_o.reg_write  = 1'b0;
    ctrl_o.mem_write  = 1'b0;
    ctrl_o.branch     = 1'b0;
    ctrl_o.jump       = 1'b0;
    ctrl_o.alu_op     = ALU_ADD;
    case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = r_ok;
        ctrl_o.alu_op    = r_op;
      end
      OP_LW: begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
      end
      OP_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      OP_J:    ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mcore_alu.sv
module mcore_alu
  import mcore_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] res_o,
  output logic            zero_o
);
  always_comb begin
    case (op_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLT: res_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile
  import mcore_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RAW-1:0]  raddr_a_i,
  input  logic [RAW-1:0]  raddr_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o,
  input  logic            we_i,
  input  logic [RAW-1:0]  waddr_i,
  input  logic [XLEN-1:0] wdata_i
);
  logic [XLEN-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && (waddr_i != '0)) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = (raddr_a_i == '0) ? '0 : regs_q[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == '0) ? '0 : regs_q[raddr_b_i];

  AST_R0_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o == '0)); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0 && raddr_a_i == waddr_i) |=>
      (rdata_a_o == $past(wdata_i) || raddr_a_i != $past(waddr_i))); // R11
endmodule

// File: rtl/mcore_top.sv
module mcore_top
  import mcore_pkg::*;
#(
  parameter int unsigned IMEM_AW = 6,
  parameter int unsigned DMEM_AW = 6
) (
  input  logic                                             clk_i,
  input  logic                                             rst_ni,
  input  logic                                             load_en_i,
  input  logic                                             load_sel_i,
  input  logic [((IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW)-1:0] load_addr_i,
  input  logic [XLEN-1:0]                                  load_data_i,
  output logic [XLEN-1:0]                                  pc_o,
  output logic                                             rf_we_o,
  output logic [RAW-1:0]                                   rf_waddr_o,
  output logic [XLEN-1:0]                                  rf_wdata_o
);
  localparam int unsigned IWORDS = 2 ** IMEM_AW;
  localparam int unsigned DWORDS = 2 ** DMEM_AW;

  logic [XLEN-1:0] imem_q [IWORDS];
  logic [XLEN-1:0] dmem_q [DWORDS];

  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_target, j_target;
  logic [XLEN-1:0] instr, imm_sext, rs_val, rt_val, alu_b, alu_res, mem_rdata, wb_data;
  logic [RAW-1:0]  waddr;
  logic            alu_zero, br_taken, dmem_we, rf_we;
  ctrl_t           ctrl;

  // preload and fetch
  always_ff @(posedge clk_i) begin
    if (load_en_i && !load_sel_i) imem_q[load_addr_i[IMEM_AW-1:0]] <= load_data_i;
  end

  assign instr = imem_q[pc_q[IMEM_AW+1:2]];

  mcore_ctrl u_ctrl (
    .opcode_i (instr[31:26]),
    .funct_i  (instr[5:0]),
    .shamt_i  (instr[10:6]),
    .ctrl_o   (ctrl)
  );

  assign waddr = ctrl.reg_dst ? instr[15:11] : instr[20:16];
  assign rf_we = ctrl.reg_write & rst_ni;

  mcore_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (instr[25:21]),
    .raddr_b_i (instr[20:16]),
    .rdata_a_o (rs_val),
    .rdata_b_o (rt_val),
    .we_i      (rf_we),
    .waddr_i   (waddr),
    .wdata_i   (wb_data)
  );

  assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b    = ctrl.alu_src ? imm_sext : rt_val;

  mcore_alu u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .op_i   (ctrl.alu_op),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  // data memory
  assign dmem_we   = ctrl.mem_write & rst_ni;
  assign mem_rdata = dmem_q[alu_res[DMEM_AW+1:2]];

  always_ff @(posedge clk_i) begin
    if (load_en_i && load_sel_i) dmem_q[load_addr_i[DMEM_AW-1:0]] <= load_data_i;
    else if (dmem_we)            dmem_q[alu_res[DMEM_AW+1:2]] <= rt_val;
  end

  assign wb_data = ctrl.mem_to_reg ? mem_rdata : alu_res;

  // next PC: branch target has its own adder
  assign pc_plus4  = pc_q + 32'd4;
  assign br_target = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign br_taken  = ctrl.branch & alu_zero;

  always_comb begin
    if (ctrl.jump)    pc_d = j_target;
    else if (br_taken) pc_d = br_target;
    else               pc_d = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we & (waddr != '0);
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_data;

  AST_STORE_NO_RF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we |-> !rf_we_o); // R5
  AST_BRANCH_NO_RF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.branch |-> (!rf_we_o && !dmem_we)); // R6
  AST_JUMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.jump |-> (!rf_we_o && !dmem_we)); // R7
  AST_JUMP_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.jump |=> (pc_q[31:28] == $past(pc_plus4[31:28]))); // R7
  AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.branch && !ctrl.jump) |=> (pc_q == $past(pc_q) + 32'd4)); // R9
  AST_SLT_BOOLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.alu_op == ALU_SLT) |-> (alu_res[XLEN-1:1] == '0)); // R3
  AST_BEQ_COMPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.branch |-> (alu_zero == (rs_val == rt_val))); // R6
endmodule

// File: tb/mcore_top_tb.sv
`timescale 1ns/1ps
module mcore_top_tb;
  localparam int AW = 6;
  localparam int NTR = 18;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_en_i = 1'b0;
  logic          load_sel_i = 1'b0;
  logic [AW-1:0] load_addr_i = '0;
  logic [31:0]   load_data_i = '0;
  logic [31:0]   pc_o;
  logic          rf_we_o;
  logic [4:0]    rf_waddr_o;
  logic [31:0]   rf_wdata_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  mcore_top #(.IMEM_AW(AW), .DMEM_AW(AW)) u_dut (
    .clk_i, .rst_ni, .load_en_i, .load_sel_i, .load_addr_i, .load_data_i,
    .pc_o, .rf_we_o, .rf_waddr_o, .rf_wdata_o
  );

  // trace of the main program, one entry per executed cycle
  localparam logic [31:0] TR_PC [NTR] = '{
    32'h00, 32'h04, 32'h08, 32'h0C, 32'h10, 32'h14, 32'h18, 32'h1C, 32'h20,
    32'h24, 32'h28, 32'h2C, 32'h30, 32'h34, 32'h38, 32'h44, 32'h50, 32'h50};
  localparam logic TR_WE [NTR] = '{
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
    1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [4:0] TR_WA [NTR] = '{
    5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd0,
    5'd9, 5'd0, 5'd10, 5'd11, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0};
  localparam logic [31:0] TR_WD [NTR] = '{
    32'h7, 32'hFFFF_FFFD, 32'h4, 32'hA, 32'h5, 32'hFFFF_FFFF, 32'h1, 32'h0, 32'h0,
    32'h7, 32'h0, 32'h4, 32'h1234_5678, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [4:0] sh,
                                        input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic load_word(input logic sel, input int addr, input logic [31:0] data);
    @(negedge clk_i);
    load_en_i   = 1'b1;
    load_sel_i  = sel;
    load_addr_i = AW'(addr);
    load_data_i = data;
    @(negedge clk_i);
    load_en_i = 1'b0;
  endtask

  task automatic check_cycle(input string tag, input logic [31:0] epc, input logic ewe,
                             input logic [4:0] ewa, input logic [31:0] ewd);
    n_vec++;
    if (pc_o !== epc || rf_we_o !== ewe ||
        (ewe && (rf_waddr_o !== ewa || rf_wdata_o !== ewd))) begin
      n_bad++;
      $display("FAIL %s: pc=%h we=%b wa=%0d wd=%h, expected pc=%h we=%b wa=%0d wd=%h",
               tag, pc_o, rf_we_o, rf_waddr_o, rf_wdata_o, epc, ewe, ewa, ewd);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: preload both memories under reset
    load_word(1'b1, 0, 32'h0000_0007);
    load_word(1'b1, 1, 32'hFFFF_FFFD);
    load_word(1'b1, 2, 32'h1234_5678);
    load_word(1'b0, 0,  enc_i(6'h23, 5'd0, 5'd1, 16'd0));        // lw r1,0(r0)     R4
    load_word(1'b0, 1,  enc_i(6'h23, 5'd0, 5'd2, 16'd4));        // lw r2,4(r0)     R4
    load_word(1'b0, 2,  enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h20));   // add             R2
    load_word(1'b0, 3,  enc_r(5'd1, 5'd2, 5'd4, 5'd0, 6'h22));   // sub             R2
    load_word(1'b0, 4,  enc_r(5'd1, 5'd2, 5'd5, 5'd0, 6'h24));   // and             R2
    load_word(1'b0, 5,  enc_r(5'd1, 5'd2, 5'd6, 5'd0, 6'h25));   // or              R2
    load_word(1'b0, 6,  enc_r(5'd2, 5'd1, 5'd7, 5'd0, 6'h2A));   // slt -3<7        R3
    load_word(1'b0, 7,  enc_r(5'd1, 5'd2, 5'd8, 5'd0, 6'h2A));   // slt 7<-3        R3
    load_word(1'b0, 8,  enc_r(5'd1, 5'd1, 5'd0, 5'd0, 6'h20));   // add r0          R8
    load_word(1'b0, 9,  enc_r(5'd0, 5'd1, 5'd9, 5'd0, 6'h20));   // add r9,r0,r1    R8
    load_word(1'b0, 10, enc_i(6'h2B, 5'd0, 5'd3, 16'd12));       // sw r3,12(r0)    R5
    load_word(1'b0, 11, enc_i(6'h23, 5'd0, 5'd10, 16'd12));      // lw r10,12(r0)   R5
    load_word(1'b0, 12, enc_i(6'h23, 5'd4, 5'd11, 16'hFFFE));    // lw r11,-2(r4)   R4
    load_word(1'b0, 13, enc_i(6'h04, 5'd1, 5'd2, 16'd5));        // beq not taken   R6
    load_word(1'b0, 14, enc_i(6'h04, 5'd3, 5'd10, 16'd2));       // beq taken       R6
    load_word(1'b0, 15, enc_r(5'd1, 5'd1, 5'd12, 5'd0, 6'h20));
    load_word(1'b0, 16, enc_r(5'd1, 5'd1, 5'd12, 5'd0, 6'h20));
    load_word(1'b0, 17, {6'h02, 26'h14});                        // j 0x50          R7
    load_word(1'b0, 18, enc_r(5'd1, 5'd1, 5'd13, 5'd0, 6'h20));
    load_word(1'b0, 19, enc_r(5'd1, 5'd1, 5'd13, 5'd0, 6'h20));
    load_word(1'b0, 20, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));     // self-loop       R6

    #1;
    check_cycle("R1 reset state", 32'h0, 1'b0, 5'd0, 32'h0);

    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NTR; i++) begin
      #1;
      check_cycle($sformatf("R11 trace[%0d]", i), TR_PC[i], TR_WE[i], TR_WA[i], TR_WD[i]);
      @(negedge clk_i);
    end

    // second program under reset: unsupported words, signed extremes, cleared regs
    rst_ni = 1'b0;
    #1;
    check_cycle("R1 mid-run reset", 32'h0, 1'b0, 5'd0, 32'h0);
    load_word(1'b1, 4, 32'h8000_0000);
    load_word(1'b1, 5, 32'h7FFF_FFFF);
    load_word(1'b0, 0,  enc_i(6'h23, 5'd0, 5'd1, 16'd0));        // r1=7
    load_word(1'b0, 1,  enc_i(6'h08, 5'd0, 5'd1, 16'd5));        // unknown opcode
    load_word(1'b0, 2,  enc_r(5'd1, 5'd1, 5'd1, 5'd3, 6'h20));   // shamt != 0
    load_word(1'b0, 3,  enc_r(5'd1, 5'd1, 5'd1, 5'd0, 6'h21));   // unknown funct
    load_word(1'b0, 4,  enc_r(5'd1, 5'd0, 5'd2, 5'd0, 6'h20));   // r2=r1
    load_word(1'b0, 5,  enc_i(6'h23, 5'd0, 5'd4, 16'd16));
    load_word(1'b0, 6,  enc_i(6'h23, 5'd0, 5'd5, 16'd20));
    load_word(1'b0, 7,  enc_r(5'd4, 5'd5, 5'd6, 5'd0, 6'h2A));
    load_word(1'b0, 8,  enc_r(5'd5, 5'd4, 5'd7, 5'd0, 6'h2A));
    load_word(1'b0, 9,  enc_r(5'd4, 5'd5, 5'd8, 5'd0, 6'h22));
    load_word(1'b0, 10, enc_r(5'd3, 5'd10, 5'd9, 5'd0, 6'h20));
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1; check_cycle("R4 lw after reset", 32'h00, 1'b1, 5'd1, 32'h7);
    @(negedge clk_i); #1; check_cycle("R9 unknown opcode", 32'h04, 1'b0, 5'd0, 32'h0);
    @(negedge clk_i); #1; check_cycle("R9 nonzero shamt", 32'h08, 1'b0, 5'd0, 32'h0);
    @(negedge clk_i); #1; check_cycle("R9 unknown funct", 32'h0C, 1'b0, 5'd0, 32'h0);
    @(negedge clk_i); #1; check_cycle("R9 r1 unchanged", 32'h10, 1'b1, 5'd2, 32'h7);
    @(negedge clk_i); #1; check_cycle("R4 lw min", 32'h14, 1'b1, 5'd4, 32'h8000_0000);
    @(negedge clk_i); #1; check_cycle("R4 lw max", 32'h18, 1'b1, 5'd5, 32'h7FFF_FFFF);
    @(negedge clk_i); #1; check_cycle("R3 slt min<max", 32'h1C, 1'b1, 5'd6, 32'h1);
    @(negedge clk_i); #1; check_cycle("R3 slt max<min", 32'h20, 1'b1, 5'd7, 32'h0);
    @(negedge clk_i); #1; check_cycle("R2 sub wraps", 32'h24, 1'b1, 5'd8, 32'h1);
    @(negedge clk_i); #1; check_cycle("R1 regs cleared", 32'h28, 1'b1, 5'd9, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule